// File: doc/BRIEF.md
# Monitor Byte Handshake Controller

This block moves command bytes across a single monitor byte that recurs once per TDM frame. A pair of active-low handshake bits accompanies that byte: MX marks a byte offered by the sender and MR marks its acceptance by the receiver. The block has both ends. Its transmitter sends bytes that the host writes. Its receiver validates incoming bytes and acknowledges them. The surrounding frame logic supplies a one-cycle `frame_strobe` for each frame. All handshake inputs are sampled on that strobe, and all handshake outputs change on it.

**Transmitter.** The host sets `mx_ctrl` and writes a byte. The transmitter then offers the byte with MX active until the peer acknowledges it, and raises `irq_ack` so the host can write the next byte. It leaves MX inactive for at least one frame between bytes. Clearing `mx_ctrl` ends the transfer. `tx_active` tells the host whether a transfer is still in progress.

**Receiver.** A byte counts as received only when the same value is seen, with MX active, on two consecutive frames. The receiver acknowledges it with one frame of MR active. If the bytes keep changing, the receiver aborts. Two consecutive frames with both handshake bits inactive mark the end of a transfer.

Top module: `mon_hs_top`

## Requirements
- R1: After reset, `mx_out` and `mr_out` are inactive (1), `tx_active` is 0 and no interrupt is raised.
- R2: The transmitter starts only when `mx_ctrl` is 1 and a written byte is pending. At the next strobe it drives the byte on `mon_out`, drives `mx_out` to 0 and sets `tx_active`. The same rule applies after a gap frame for each following byte.
- R3: While sending, a strobe that samples `mr_in`=0 raises `irq_ack` for one cycle. At that same strobe `mx_out` returns to 1 for at least one frame.
- R4: If `mx_ctrl` is 0 after an acknowledge, `mx_out` stays 1. `tx_active` clears at the second consecutive strobe with `mx_out`=1 and `mr_in`=1.
- R5: If no acknowledge arrives within ABORT_FRAMES strobes after a byte starts, `irq_tx_abort` pulses. At the same time `mx_out` returns to 1, `tx_active` clears and the pending byte is dropped.
- R6: When two consecutive strobes see `mx_in`=0 with equal `mon_in`, the receiver loads `rx_data` and drives `mr_out`=0 for exactly one frame.
- R7: `irq_rx` pulses on acceptance only if `rx_int_en` and `mr_ctrl` are both 1. With `rx_int_en`=0 the byte is still accepted and acknowledged. With `mr_ctrl`=0 the receiver ignores the channel: `mr_out` stays 1 and no receive interrupt fires.
- R8: A first mismatch between looks restarts validation with the new byte. A second mismatch raises `irq_rx_err`, and MR then stays inactive until two consecutive quiet frames occur.
- R9: After at least one accepted byte, the second consecutive strobe with `mx_in`=1 and `mr_in`=1 raises `irq_end`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_strobe | input | 1 | One-cycle pulse per frame; handshake sampling point |
| host_wr | input | 1 | Host write of the next byte to send |
| host_data | input | 8 | Byte to send |
| mx_ctrl | input | 1 | Transmit enable; clearing it ends the transfer |
| mr_ctrl | input | 1 | Receiver enable |
| rx_int_en | input | 1 | Receive interrupt enable |
| mon_in | input | 8 | Incoming monitor byte |
| mx_in | input | 1 | Incoming MX, active low |
| mr_in | input | 1 | Incoming MR, active low |
| mon_out | output | 8 | Outgoing monitor byte |
| mx_out | output | 1 | Outgoing MX, active low |
| mr_out | output | 1 | Outgoing MR, active low |
| tx_active | output | 1 | Transfer in progress |
| rx_data | output | 8 | Last accepted byte |
| irq_ack | output | 1 | Byte acknowledged pulse |
| irq_rx | output | 1 | Byte received pulse |
| irq_end | output | 1 | Receive end of transfer pulse |
| irq_tx_abort | output | 1 | Transmit abort pulse |
| irq_rx_err | output | 1 | Receive abort pulse |

## Verification
Every result is due at the rising edge that samples `frame_strobe`, with no extra latency. Interrupts are one-cycle pulses on that edge, and levels such as `mx_out`, `mr_out` and `tx_active` change there. The bench drives one frame per task call and samples on the falling edge right after the strobe edge. A scoreboard queue holds the expected interrupts, pushed just before the frame that must produce them. The monitor compares every pulse it sees against the head of that queue, so both an early pulse and a missing pulse are reported.

// File: rtl/mon_hs_pkg.sv
package mon_hs_pkg;
    localparam logic HS_ON  = 1'b0;
    localparam logic HS_OFF = 1'b1;

    typedef enum logic [1:0] {T_IDLE, T_SEND, T_GAP, T_END} tx_state_e;
    typedef enum logic [2:0] {R_IDLE, R_LOOK, R_ACK, R_REL, R_ERR} rx_state_e;

    function automatic logic hs_on(input logic b);
        return b == HS_ON;
    endfunction
endpackage

// File: rtl/mon_hs_tx.sv
module mon_hs_tx
    import mon_hs_pkg::*;
#(
    parameter int DW           = 8,
    parameter int ABORT_FRAMES = 8,
    parameter int END_FRAMES   = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          frame_strobe,
    input  logic          host_wr,
    input  logic [DW-1:0] host_data,
    input  logic          mx_ctrl,
    input  logic          mr_in,
    output logic [DW-1:0] mon_out,
    output logic          mx_out,
    output logic          tx_active,
    output logic          irq_ack,
    output logic          irq_abort
);
    localparam int AW = $clog2(ABORT_FRAMES + 1);
    localparam int EW = $clog2(END_FRAMES + 1);

    tx_state_e     state;
    logic          pend;
    logic [DW-1:0] pend_data;
    logic [AW-1:0] acnt;
    logic [EW-1:0] ecnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= T_IDLE;
            pend      <= 1'b0;
            pend_data <= '0;
            mon_out   <= '0;
            mx_out    <= HS_OFF;
            tx_active <= 1'b0;
            acnt      <= '0;
            ecnt      <= '0;
            irq_ack   <= 1'b0;
            irq_abort <= 1'b0;
        end else begin
            irq_ack   <= 1'b0;
            irq_abort <= 1'b0;
            if (frame_strobe) begin
                case (state)
                    T_IDLE, T_GAP: begin
                        if (mx_ctrl && pend) begin
                            mon_out   <= pend_data;
                            mx_out    <= HS_ON;
                            pend      <= 1'b0;
                            tx_active <= 1'b1;
                            acnt      <= '0;
                            state     <= T_SEND;
                        end else if (state == T_GAP && !mx_ctrl) begin
                            ecnt  <= hs_on(mr_in) ? EW'(0) : EW'(1);
                            state <= T_END;
                        end
                    end
                    T_SEND: begin
                        if (hs_on(mr_in)) begin
                            irq_ack <= 1'b1;
                            mx_out  <= HS_OFF;
                            state   <= T_GAP;
                        end else if (acnt == AW'(ABORT_FRAMES - 1)) begin
                            irq_abort <= 1'b1;
                            mx_out    <= HS_OFF;
                            tx_active <= 1'b0;
                            pend      <= 1'b0;
                            state     <= T_IDLE;
                        end else begin
                            acnt <= acnt + AW'(1);
                        end
                    end
                    T_END: begin
                        if (hs_on(mr_in)) begin
                            ecnt <= '0;
                        end else if (ecnt >= EW'(END_FRAMES - 1)) begin
                            tx_active <= 1'b0;
                            state     <= T_IDLE;
                        end else begin
                            ecnt <= ecnt + EW'(1);
                        end
                    end
                    default: state <= T_IDLE;
                endcase
            end
            if (host_wr) begin
                pend      <= 1'b1;
                pend_data <= host_data;
            end
        end
    end

    AST_START_ACTIVE: assert property (@(posedge clk) disable iff (rst)
        $fell(mx_out) |-> tx_active);                               // R2
    AST_ACK_RELEASES_MX: assert property (@(posedge clk) disable iff (rst)
        irq_ack |-> (mx_out == HS_OFF && $past(mx_out) == HS_ON));  // R3
    AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (rst)
        irq_abort |-> (!tx_active && mx_out == HS_OFF));            // R5
    AST_ACK_NOT_ABORT: assert property (@(posedge clk) disable iff (rst)
        !(irq_ack && irq_abort));                                   // R5
endmodule

// File: rtl/mon_hs_rx.sv
module mon_hs_rx
    import mon_hs_pkg::*;
#(
    parameter int DW         = 8,
    parameter int END_FRAMES = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          frame_strobe,
    input  logic          mr_ctrl,
    input  logic          rx_int_en,
    input  logic [DW-1:0] mon_in,
    input  logic          mx_in,
    input  logic          mr_in,
    output logic          mr_out,
    output logic [DW-1:0] rx_data,
    output logic          irq_rx,
    output logic          irq_end,
    output logic          irq_err
);
    localparam int QW = $clog2(END_FRAMES + 1);

    rx_state_e     state;
    logic [DW-1:0] look;
    logic          retry;
    logic          in_xfer;
    logic [QW-1:0] qcnt;
    logic          quiet;
    logic          quiet_done;

    assign quiet      = !hs_on(mx_in) && !hs_on(mr_in);
    assign quiet_done = quiet && (qcnt >= QW'(END_FRAMES - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= R_IDLE;
            look    <= '0;
            retry   <= 1'b0;
            in_xfer <= 1'b0;
            qcnt    <= '0;
            mr_out  <= HS_OFF;
            rx_data <= '0;
            irq_rx  <= 1'b0;
            irq_end <= 1'b0;
            irq_err <= 1'b0;
        end else begin
            irq_rx  <= 1'b0;
            irq_end <= 1'b0;
            irq_err <= 1'b0;
            if (frame_strobe) begin
                if (!quiet)
                    qcnt <= '0;
                else if (qcnt < QW'(END_FRAMES))
                    qcnt <= qcnt + QW'(1);
                if (in_xfer && quiet_done) begin
                    irq_end <= 1'b1;
                    in_xfer <= 1'b0;
                end
                if (!mr_ctrl) begin
                    state  <= R_IDLE;
                    mr_out <= HS_OFF;
                end else begin
                    case (state)
                        R_IDLE: if (hs_on(mx_in)) begin
                            look  <= mon_in;
                            retry <= 1'b0;
                            state <= R_LOOK;
                        end
                        R_LOOK: begin
                            if (!hs_on(mx_in)) begin
                                state <= R_IDLE;
                            end else if (mon_in == look) begin
                                rx_data <= mon_in;
                                mr_out  <= HS_ON;
                                in_xfer <= 1'b1;
                                irq_rx  <= rx_int_en;
                                state   <= R_ACK;
                            end else if (!retry) begin
                                look  <= mon_in;
                                retry <= 1'b1;
                            end else begin
                                irq_err <= 1'b1;
                                in_xfer <= 1'b0;
                                state   <= R_ERR;
                            end
                        end
                        R_ACK: begin
                            mr_out <= HS_OFF;
                            state  <= R_REL;
                        end
                        R_REL: if (!hs_on(mx_in)) state <= R_IDLE;
                        R_ERR: if (quiet_done) state <= R_IDLE;
                        default: state <= R_IDLE;
                    endcase
                end
            end
        end
    end

    AST_MR_ONE_FRAME: assert property (@(posedge clk) disable iff (rst)
        (frame_strobe && mr_out == HS_ON) |=> mr_out == HS_OFF);       // R6
    AST_RX_GATED: assert property (@(posedge clk) disable iff (rst)
        irq_rx |-> $past(rx_int_en && mr_ctrl));                       // R7
    AST_DISABLED_SILENT: assert property (@(posedge clk) disable iff (rst)
        (frame_strobe && !mr_ctrl) |=> (mr_out == HS_OFF && !irq_rx)); // R7
    AST_ERR_NO_ACK: assert property (@(posedge clk) disable iff (rst)
        irq_err |-> (mr_out == HS_OFF && !irq_rx));                    // R8
endmodule

// File: rtl/mon_hs_top.sv
module mon_hs_top
    import mon_hs_pkg::*;
#(
    parameter int DW           = 8,
    parameter int ABORT_FRAMES = 8,
    parameter int END_FRAMES   = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          frame_strobe,
    input  logic          host_wr,
    input  logic [DW-1:0] host_data,
    input  logic          mx_ctrl,
    input  logic          mr_ctrl,
    input  logic          rx_int_en,
    input  logic [DW-1:0] mon_in,
    input  logic          mx_in,
    input  logic          mr_in,
    output logic [DW-1:0] mon_out,
    output logic          mx_out,
    output logic          mr_out,
    output logic          tx_active,
    output logic [DW-1:0] rx_data,
    output logic          irq_ack,
    output logic          irq_rx,
    output logic          irq_end,
    output logic          irq_tx_abort,
    output logic          irq_rx_err
);
    mon_hs_tx #(.DW(DW), .ABORT_FRAMES(ABORT_FRAMES), .END_FRAMES(END_FRAMES)) tx_i (
        .clk(clk), .rst(rst), .frame_strobe(frame_strobe),
        .host_wr(host_wr), .host_data(host_data), .mx_ctrl(mx_ctrl),
        .mr_in(mr_in), .mon_out(mon_out), .mx_out(mx_out),
        .tx_active(tx_active), .irq_ack(irq_ack), .irq_abort(irq_tx_abort)
    );

    mon_hs_rx #(.DW(DW), .END_FRAMES(END_FRAMES)) rx_i (
        .clk(clk), .rst(rst), .frame_strobe(frame_strobe),
        .mr_ctrl(mr_ctrl), .rx_int_en(rx_int_en), .mon_in(mon_in),
        .mx_in(mx_in), .mr_in(mr_in), .mr_out(mr_out), .rx_data(rx_data),
        .irq_rx(irq_rx), .irq_end(irq_end), .irq_err(irq_rx_err)
    );

    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(rst) |-> (mx_out == HS_OFF && mr_out == HS_OFF && !tx_active)); // R1
endmodule

// File: tb/mon_hs_top_tb_top.sv
module mon_hs_top_tb_top;
    localparam int ABORT = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       frame_strobe = 1'b0;
    logic       host_wr = 1'b0;
    logic [7:0] host_data = '0;
    logic       mx_ctrl = 1'b0, mr_ctrl = 1'b0, rx_int_en = 1'b0;
    logic [7:0] mon_in = '0;
    logic       mx_in = 1'b1, mr_in = 1'b1;
    logic [7:0] mon_out, rx_data;
    logic       mx_out, mr_out, tx_active;
    logic       irq_ack, irq_rx, irq_end, irq_tx_abort, irq_rx_err;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        int         kind;
        logic [7:0] data;
        string      req;
    } ev_t;
    ev_t exp_q[$];
    localparam int EV_ACK = 0, EV_RX = 1, EV_END = 2, EV_TXAB = 3, EV_RXERR = 4;

    always #2.5 clk = ~clk;

    mon_hs_top #(.ABORT_FRAMES(ABORT)) dut_i (
        .clk(clk), .rst(rst), .frame_strobe(frame_strobe),
        .host_wr(host_wr), .host_data(host_data), .mx_ctrl(mx_ctrl),
        .mr_ctrl(mr_ctrl), .rx_int_en(rx_int_en), .mon_in(mon_in),
        .mx_in(mx_in), .mr_in(mr_in), .mon_out(mon_out), .mx_out(mx_out),
        .mr_out(mr_out), .tx_active(tx_active), .rx_data(rx_data),
        .irq_ack(irq_ack), .irq_rx(irq_rx), .irq_end(irq_end),
        .irq_tx_abort(irq_tx_abort), .irq_rx_err(irq_rx_err)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic expect_ev(input int kind, input logic [7:0] data, input string req);
        ev_t e;
        e.kind = kind;
        e.data = data;
        e.req  = req;
        exp_q.push_back(e);
    endtask

    task automatic do_frame(input logic [7:0] m, input logic mx, input logic mr);
        @(negedge clk);
        @(negedge clk);
        mon_in = m;
        mx_in = mx;
        mr_in = mr;
        frame_strobe = 1'b1;
        @(negedge clk);
        frame_strobe = 1'b0;
    endtask

    task automatic write_byte(input logic [7:0] b);
        @(negedge clk);
        host_wr = 1'b1;
        host_data = b;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    // scoreboard monitor: every interrupt pulse must match the queue head
    initial begin
        forever begin
            @(negedge clk);
            if (!rst) begin
                for (int k = 0; k < 5; k++) begin
                    logic hit;
                    hit = (k == EV_ACK) ? irq_ack : (k == EV_RX) ? irq_rx :
                          (k == EV_END) ? irq_end : (k == EV_TXAB) ? irq_tx_abort : irq_rx_err;
                    if (hit) begin
                        checks++;
                        if (exp_q.size() == 0) begin
                            fails++;
                            $display("FAIL unexpected irq: actual kind %0d expected none", k);
                        end else begin
                            ev_t e;
                            e = exp_q.pop_front();
                            if (e.kind != k || (k == EV_RX && rx_data != e.data)) begin
                                fails++;
                                $display("FAIL %s: actual kind %0d data %0h expected kind %0d data %0h",
                                         e.req, k, rx_data, e.kind, e.data);
                            end
                        end
                    end
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 mx_out", mx_out, 1);
        check("R1 mr_out", mr_out, 1);
        check("R1 tx_active", tx_active, 0);

        // ---- transmitter ----
        mx_ctrl = 1'b1;
        write_byte(8'hA5);
        do_frame(8'h00, 1'b1, 1'b1);
        check("R2 mx_out start", mx_out, 0);
        check("R2 mon_out", mon_out, 8'hA5);
        check("R2 tx_active", tx_active, 1);
        do_frame(8'h00, 1'b1, 1'b1);
        check("R3 mx held until ack", mx_out, 0);
        expect_ev(EV_ACK, 8'h00, "R3 ack irq");
        do_frame(8'h00, 1'b1, 1'b0);
        check("R3 mx released", mx_out, 1);
        write_byte(8'h3C);
        do_frame(8'h00, 1'b1, 1'b1);
        check("R2 second byte mx", mx_out, 0);
        check("R2 second byte data", mon_out, 8'h3C);
        expect_ev(EV_ACK, 8'h00, "R3 ack irq 2");
        do_frame(8'h00, 1'b1, 1'b0);
        check("R3 mx released 2", mx_out, 1);
        mx_ctrl = 1'b0;
        do_frame(8'h00, 1'b1, 1'b1);
        check("R4 still active", tx_active, 1);
        check("R4 mx inactive", mx_out, 1);
        do_frame(8'h00, 1'b1, 1'b1);
        check("R4 end clears active", tx_active, 0);

        // R5 abort
        mx_ctrl = 1'b1;
        write_byte(8'h77);
        do_frame(8'h00, 1'b1, 1'b1);
        check("R5 abort start", mx_out, 0);
        for (int i = 0; i < ABORT - 1; i++) do_frame(8'h00, 1'b1, 1'b1);
        check("R5 before abort", mx_out, 0);
        expect_ev(EV_TXAB, 8'h00, "R5 abort irq");
        do_frame(8'h00, 1'b1, 1'b1);
        check("R5 mx after abort", mx_out, 1);
        check("R5 active after abort", tx_active, 0);
        mx_ctrl = 1'b0;
        do_frame(8'h00, 1'b1, 1'b1);
        check("R5 pending dropped", mx_out, 1);

        // ---- receiver ----
        mr_ctrl = 1'b1;
        rx_int_en = 1'b1;
        do_frame(8'h5A, 1'b0, 1'b1);
        check("R6 no ack on first look", mr_out, 1);
        expect_ev(EV_RX, 8'h5A, "R6 rx irq");
        do_frame(8'h5A, 1'b0, 1'b1);
        check("R6 mr active", mr_out, 0);
        check("R6 rx_data", rx_data, 8'h5A);
        do_frame(8'h5A, 1'b0, 1'b1);
        check("R6 mr one frame", mr_out, 1);
        do_frame(8'h00, 1'b1, 1'b1);
        do_frame(8'hC3, 1'b0, 1'b1);
        rx_int_en = 1'b0;
        do_frame(8'hC3, 1'b0, 1'b1);
        check("R7 ack without irq", mr_out, 0);
        check("R7 rx_data", rx_data, 8'hC3);
        rx_int_en = 1'b1;
        do_frame(8'hC3, 1'b0, 1'b1);
        do_frame(8'h00, 1'b1, 1'b1);
        expect_ev(EV_END, 8'h00, "R9 end irq");
        do_frame(8'h00, 1'b1, 1'b1);

        // R8 mismatch abort
        do_frame(8'h11, 1'b0, 1'b1);
        do_frame(8'h22, 1'b0, 1'b1);
        check("R8 no ack after first mismatch", mr_out, 1);
        expect_ev(EV_RXERR, 8'h00, "R8 err irq");
        do_frame(8'h33, 1'b0, 1'b1);
        check("R8 mr inactive on err", mr_out, 1);
        do_frame(8'h33, 1'b0, 1'b1);
        check("R8 mr held inactive", mr_out, 1);
        do_frame(8'h00, 1'b1, 1'b1);
        do_frame(8'h00, 1'b1, 1'b1);
        // R8 restart after one mismatch
        do_frame(8'h44, 1'b0, 1'b1);
        do_frame(8'h55, 1'b0, 1'b1);
        expect_ev(EV_RX, 8'h55, "R8 restart rx irq");
        do_frame(8'h55, 1'b0, 1'b1);
        check("R8 restart ack", mr_out, 0);
        do_frame(8'h55, 1'b0, 1'b1);
        do_frame(8'h00, 1'b1, 1'b1);
        expect_ev(EV_END, 8'h00, "R9 end irq 2");
        do_frame(8'h00, 1'b1, 1'b1);

        // R7 receiver disabled ignores the channel
        mr_ctrl = 1'b0;
        for (int i = 0; i < 3; i++) begin
            do_frame(8'h66, 1'b0, 1'b1);
            check("R7 disabled mr_out", mr_out, 1);
        end
        do_frame(8'h00, 1'b1, 1'b1);
        do_frame(8'h00, 1'b1, 1'b1);

        repeat (4) @(negedge clk);
        while (exp_q.size() > 0) begin
            ev_t e;
            e = exp_q.pop_front();
            checks++;
            fails++;
            $display("FAIL %s: actual missing expected kind %0d", e.req, e.kind);
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule